// File: doc/BRIEF.md
# Sectored Flash Command Controller

This block sits between a microcontroller bus and a small register-based model of a sectored flash array. The array has twelve equal sectors: eight primary ones and four secondary ones, all reached through one byte-wide bus. Plain reads return stored bytes, as a ROM would. A single write never alters the array. Content changes only through multi-write command sequences. Each sequence starts with two unlock writes and then selects either a byte program or a sector erase, both timed by parameter-set cycle counts.

Each sector can be locked by a configuration input. A locked sector turns away program and erase commands without touching its data. A ready output is low while an operation runs. Progress can also be followed through the array space with a polling status byte. A sector erase can be paused so that the other sectors can be read, and then continued. An identifier mode returns the maker and device codes and the lock state of any chosen sector.

Top module: `sector_flash_ctrl`

## Requirements
- R1: After a synchronous reset, the controller is in read mode, `ready` is 1, `bus_rdata` is 0x00, and every array byte reads 0xFF.
- R2: A read while the controller is idle returns the byte at sector `bus_addr[7:4]` and offset `bus_addr[3:0]`. Sectors 0–7 are primary and 8–11 are secondary. Sector numbers 12–15 read 0xFF. `bus_rdata` is updated on the clock edge that samples `bus_re` and holds its value while no read is made.
- R3: A lone write never changes the array. The unlock pair is 0xAA written to address 0x555, then 0x55 written to 0x2AA (compared on `bus_addr[10:0]`). The command byte that follows is written to 0x555.
- R4: Program uses the unlock pair, then 0xA0, then one write of the target address and data. When the operation finishes, the stored byte becomes old AND data.
- R5: Sector erase uses the unlock pair, then 0x80, then a second unlock pair, then 0x30 written to any address inside the sector. When it finishes, every byte of that sector reads 0xFF and other sectors are unchanged.
- R6: A program or erase aimed at a sector whose `sector_lock` bit is 1 is refused. `ready` stays 1, the data is unchanged, and the controller returns to read mode.
- R7: `ready` is 0 starting with the cycle after the write that starts an operation. It stays 0 for exactly PROG_CYCLES cycles (program) or ERASE_CYCLES cycles (erase), then returns to 1.
- R8: While an operation runs, every read returns a status byte. Bit 7 is the complement of bit 7 of the target data (the program data, or 0xFF for an erase). Bit 6 is a toggle that is 0 on the first read of the operation and flips after each status read. Bits 5:0 are 0. Writes during a program are ignored.
- R9: Writing 0xB0 during an erase suspends it. `ready` goes to 1 and the remaining cycle count is held. Reads of other sectors return array data. Reads of the erasing sector return the status byte of R8. Writing 0x30 resumes the erase, which then runs for the remaining count plus one cycle. Other writes during suspend are ignored.
- R10: The unlock pair followed by 0x90 enters identifier mode. There, offset 0 of any sector reads MFR_ID (0x20), offset 1 reads DEV_ID (0xE3), offset 2 reads 0x01 if the addressed sector is locked and 0x00 if not, and other offsets read 0x00. Any write returns the controller to read mode.
- R11: A write that does not match the expected next step of a sequence, including 0xF0, ends the sequence and returns the controller to read mode. The following writes are then treated as fresh bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| sector_lock | input | 12 | Lock bit for each sector; bit n locks sector n |
| bus_rdata | output | 8 | Read data, registered |
| ready | output | 1 | 1 when no program or erase is running |

## Verification
Read data appears on `bus_rdata` one clock after the edge that samples `bus_re`. The bench raises each strobe at a falling edge and compares the result at the next falling edge. `ready` falls right after the edge that takes the final command write and rises PROG_CYCLES or ERASE_CYCLES edges later. After a resume, it rises after the held count plus one edge. The bench checks `ready` at every falling edge across those windows, so both an early and a late release are caught. Array contents are read back only after an idle gap longer than the operation, except where the status byte itself is under test.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int BUS_AW = 12;
    localparam int BUS_DW = 8;

    typedef enum logic [3:0] {
        M_READ, M_UNL1, M_UNL2, M_PGM_ARG,
        M_ERS_SET, M_ERS_UNL1, M_ERS_UNL2, M_ID,
        M_PGM_BUSY, M_ERS_BUSY, M_ERS_SUSP
    } mode_e;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_cmd_t;

    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [7:0]  OP_PROGRAM = 8'hA0;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  OP_IDENT   = 8'h90;
    localparam logic [7:0]  OP_CONFIRM = 8'h30;
    localparam logic [7:0]  OP_PAUSE   = 8'hB0;
    localparam logic [7:0]  OP_CONT    = 8'h30;

    function automatic logic is_running(input mode_e m);
        return (m == M_PGM_BUSY) || (m == M_ERS_BUSY);
    endfunction

    function automatic logic [7:0] poll_byte(input logic tgt_msb, input logic tog);
        return {~tgt_msb, tog, 6'b000000};
    endfunction

endpackage

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter  int NSEC         = 12,
    parameter  int SECTOR_BYTES = 16,
    localparam int SEC_W        = $clog2(NSEC),
    localparam int OFF_W        = $clog2(SECTOR_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEC_W-1:0] rd_sec,
    input  logic [OFF_W-1:0] rd_off,
    input  logic             pgm_en,
    input  logic [SEC_W-1:0] pgm_sec,
    input  logic [OFF_W-1:0] pgm_off,
    input  logic [7:0]       pgm_data,
    input  logic             ers_en,
    input  logic [SEC_W-1:0] ers_sec,
    output logic [7:0]       rd_byte
);

    logic [NSEC-1:0][7:0] sec_rd;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic [7:0] cells [SECTOR_BYTES];
        logic       hit_pgm;
        logic       hit_ers;

        assign hit_pgm = pgm_en && (pgm_sec == SEC_W'(s));
        assign hit_ers = ers_en && (ers_sec == SEC_W'(s));

        always_ff @(posedge clk) begin
            if (rst || hit_ers) begin
                for (int b = 0; b < SECTOR_BYTES; b++) cells[b] <= 8'hFF;
            end else if (hit_pgm) begin
                cells[pgm_off] <= cells[pgm_off] & pgm_data;
            end
        end

        assign sec_rd[s] = cells[rd_off];

        // R4: every bit clear in the program data is clear afterwards
        p_pgm_clears_r4: assert property (@(posedge clk) disable iff (rst)
            hit_pgm |=> ((cells[$past(pgm_off)] & ~$past(pgm_data)) == 8'h00));

        // R5: an erased sector reads 0xFF at both ends
        p_erase_fill_r5: assert property (@(posedge clk) disable iff (rst)
            hit_ers |=> (cells[0] == 8'hFF) && (cells[SECTOR_BYTES-1] == 8'hFF));
    end

    assign rd_byte = (int'(rd_sec) < NSEC) ? sec_rd[rd_sec] : 8'hFF;

endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import fcc_pkg::*;
#(
    parameter  int NSEC         = 12,
    parameter  int SECTOR_BYTES = 16,
    parameter  int PROG_CYCLES  = 8,
    parameter  int ERASE_CYCLES = 64,
    localparam int SEC_W        = $clog2(NSEC),
    localparam int OFF_W        = $clog2(SECTOR_BYTES),
    localparam int CNT_MAX      = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int CNT_W        = $clog2(CNT_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_cmd_t              cmd,
    input  logic [2**SEC_W-1:0]   lock_pad,
    input  logic                  poll_rd,
    output mode_e                 mode,
    output logic [SEC_W-1:0]      tgt_sec,
    output logic [OFF_W-1:0]      tgt_off,
    output logic [7:0]            tgt_data,
    output logic                  tog,
    output logic                  pgm_commit,
    output logic                  ers_commit
);

    logic [CNT_W-1:0] cnt;
    logic [SEC_W-1:0] addr_sec;
    logic [OFF_W-1:0] addr_off;
    logic             at_a, key_a, key_b, locked;

    assign addr_sec = cmd.addr[OFF_W +: SEC_W];
    assign addr_off = cmd.addr[OFF_W-1:0];
    assign at_a     = cmd.addr[10:0] == KEY_ADDR_A;
    assign key_a    = at_a && (cmd.data == KEY_A);
    assign key_b    = (cmd.addr[10:0] == KEY_ADDR_B) && (cmd.data == KEY_B);
    assign locked   = lock_pad[addr_sec];

    assign pgm_commit = (mode == M_PGM_BUSY) && (cnt == '0);
    assign ers_commit = (mode == M_ERS_BUSY) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= M_READ;
            cnt      <= '0;
            tog      <= 1'b0;
            tgt_sec  <= '0;
            tgt_off  <= '0;
            tgt_data <= '0;
        end else begin
            if (poll_rd) tog <= ~tog;
            case (mode)
                M_PGM_BUSY: begin
                    if (cnt == '0) mode <= M_READ;
                    else           cnt  <= cnt - 1'b1;
                end
                M_ERS_BUSY: begin
                    if (cnt == '0)                             mode <= M_READ;
                    else if (cmd.we && cmd.data == OP_PAUSE)   mode <= M_ERS_SUSP;
                    else                                       cnt  <= cnt - 1'b1;
                end
                M_ERS_SUSP: begin
                    if (cmd.we && cmd.data == OP_CONT) mode <= M_ERS_BUSY;
                end
                default: begin
                    if (cmd.we) begin
                        mode <= M_READ;
                        case (mode)
                            M_READ:     if (key_a) mode <= M_UNL1;
                            M_UNL1:     if (key_b) mode <= M_UNL2;
                            M_UNL2: begin
                                if (at_a && cmd.data == OP_PROGRAM) mode <= M_PGM_ARG;
                                if (at_a && cmd.data == OP_ERASE)   mode <= M_ERS_SET;
                                if (at_a && cmd.data == OP_IDENT)   mode <= M_ID;
                            end
                            M_PGM_ARG: begin
                                if (!locked) begin
                                    mode     <= M_PGM_BUSY;
                                    cnt      <= CNT_W'(PROG_CYCLES - 1);
                                    tog      <= 1'b0;
                                    tgt_sec  <= addr_sec;
                                    tgt_off  <= addr_off;
                                    tgt_data <= cmd.data;
                                end
                            end
                            M_ERS_SET:  if (key_a) mode <= M_ERS_UNL1;
                            M_ERS_UNL1: if (key_b) mode <= M_ERS_UNL2;
                            M_ERS_UNL2: begin
                                if (cmd.data == OP_CONFIRM && !locked) begin
                                    mode     <= M_ERS_BUSY;
                                    cnt      <= CNT_W'(ERASE_CYCLES - 1);
                                    tog      <= 1'b0;
                                    tgt_sec  <= addr_sec;
                                    tgt_off  <= '0;
                                    tgt_data <= 8'hFF;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    // R6: an operation only starts on an unlocked sector
    p_lock_refused_r6: assert property (@(posedge clk) disable iff (rst)
        (is_running(mode) && ($past(mode) == M_PGM_ARG || $past(mode) == M_ERS_UNL2))
        |-> !$past(lock_pad[addr_sec]));

    // R7: the program window never exceeds its cycle budget
    p_pgm_window_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == M_PGM_BUSY) |-> (cnt < CNT_W'(PROG_CYCLES)));

    // R8: each status read flips the toggle bit
    p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (poll_rd && !cmd.we) |=> (tog != $past(tog)));

    // R9: the remaining erase count is frozen while suspended
    p_susp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ERS_SUSP && $past(mode) == M_ERS_SUSP) |-> $stable(cnt));

endmodule

// File: rtl/sector_flash_ctrl.sv
module sector_flash_ctrl
    import fcc_pkg::*;
#(
    parameter  int          PRI_SECTORS  = 8,
    parameter  int          SEC_SECTORS  = 4,
    parameter  int          SECTOR_BYTES = 16,
    parameter  int          PROG_CYCLES  = 8,
    parameter  int          ERASE_CYCLES = 64,
    parameter  logic [7:0]  MFR_ID       = 8'h20,
    parameter  logic [7:0]  DEV_ID       = 8'hE3,
    localparam int          NSEC         = PRI_SECTORS + SEC_SECTORS,
    localparam int          SEC_W        = $clog2(NSEC),
    localparam int          OFF_W        = $clog2(SECTOR_BYTES),
    localparam int          PAD_N        = 2**SEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic [NSEC-1:0]   sector_lock,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              ready
);

    bus_cmd_t         cmd;
    mode_e            mode;
    logic [SEC_W-1:0] tgt_sec;
    logic [OFF_W-1:0] tgt_off;
    logic [7:0]       tgt_data;
    logic             tog, pgm_commit, ers_commit, poll_rd, on_tgt;
    logic [SEC_W-1:0] rd_sec;
    logic [OFF_W-1:0] rd_off;
    logic [7:0]       arr_byte, id_byte, rd_next;
    logic [PAD_N-1:0] lock_pad;

    assign cmd = '{we: bus_we, re: bus_re, addr: bus_addr, data: bus_wdata};

    // Sector numbers past the last sector count as locked.
    if (PAD_N > NSEC) begin : g_pad
        assign lock_pad = {{(PAD_N - NSEC){1'b1}}, sector_lock};
    end else begin : g_nopad
        assign lock_pad = sector_lock;
    end

    assign rd_sec = bus_addr[OFF_W +: SEC_W];
    assign rd_off = bus_addr[OFF_W-1:0];

    fcc_seq #(
        .NSEC(NSEC), .SECTOR_BYTES(SECTOR_BYTES),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_seq (
        .clk, .rst, .cmd, .lock_pad, .poll_rd,
        .mode, .tgt_sec, .tgt_off, .tgt_data, .tog, .pgm_commit, .ers_commit
    );

    fcc_array #(.NSEC(NSEC), .SECTOR_BYTES(SECTOR_BYTES)) u_arr (
        .clk, .rst, .rd_sec, .rd_off,
        .pgm_en(pgm_commit), .pgm_sec(tgt_sec), .pgm_off(tgt_off), .pgm_data(tgt_data),
        .ers_en(ers_commit), .ers_sec(tgt_sec), .rd_byte(arr_byte)
    );

    assign ready   = ~is_running(mode);
    assign on_tgt  = rd_sec == tgt_sec;
    assign poll_rd = bus_re && (is_running(mode) || (mode == M_ERS_SUSP && on_tgt));

    always_comb begin
        case (rd_off[1:0])
            2'd0:    id_byte = MFR_ID;
            2'd1:    id_byte = DEV_ID;
            2'd2:    id_byte = {7'b0000000, lock_pad[rd_sec]};
            default: id_byte = 8'h00;
        endcase
        if (rd_off > OFF_W'(3)) id_byte = 8'h00;
    end

    always_comb begin
        if (poll_rd)             rd_next = poll_byte(tgt_data[7], tog);
        else if (mode == M_ID)   rd_next = id_byte;
        else                     rd_next = arr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_next;
    end

    // R2: read data holds when no read is made
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/sim_sector_flash_ctrl.sv
`timescale 1ns/1ps
module sim_sector_flash_ctrl;

    localparam int PROG_CYCLES  = 8;
    localparam int ERASE_CYCLES = 64;

    localparam logic [2:0] T_WR = 3'd0, T_RD = 3'd1, T_IDLE = 3'd2, T_PGM = 3'd3, T_ERS = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VECS [NV] = '{
        '{T_RD,   4'd1,  12'h000, 8'hFF},   // R1 erased after reset
        '{T_RD,   4'd1,  12'h0B5, 8'hFF},   // R1
        '{T_WR,   4'd3,  12'h013, 8'h00},   // R3 lone write
        '{T_RD,   4'd3,  12'h013, 8'hFF},   // R3 unchanged
        '{T_PGM,  4'd4,  12'h013, 8'h5A},   // R4
        '{T_IDLE, 4'd4,  12'h000, 8'd10},
        '{T_RD,   4'd4,  12'h013, 8'h5A},   // R4
        '{T_PGM,  4'd4,  12'h013, 8'h0F},   // R4 AND
        '{T_IDLE, 4'd4,  12'h000, 8'd10},
        '{T_RD,   4'd4,  12'h013, 8'h0A},   // R4
        '{T_PGM,  4'd2,  12'h092, 8'h3C},   // R2 secondary sector
        '{T_IDLE, 4'd2,  12'h000, 8'd10},
        '{T_RD,   4'd2,  12'h092, 8'h3C},   // R2
        '{T_RD,   4'd2,  12'h0C0, 8'hFF},   // R2 beyond last sector
        '{T_WR,   4'd11, 12'h555, 8'hAA},   // R11 bad second key
        '{T_WR,   4'd11, 12'h2AA, 8'h11},
        '{T_WR,   4'd11, 12'h555, 8'hA0},
        '{T_WR,   4'd11, 12'h013, 8'h00},
        '{T_IDLE, 4'd11, 12'h000, 8'd10},
        '{T_RD,   4'd11, 12'h013, 8'h0A},   // R11
        '{T_WR,   4'd11, 12'h555, 8'hAA},   // R11 reset command
        '{T_WR,   4'd11, 12'h2AA, 8'h55},
        '{T_WR,   4'd11, 12'h555, 8'hF0},
        '{T_WR,   4'd11, 12'h013, 8'h00},
        '{T_IDLE, 4'd11, 12'h000, 8'd10},
        '{T_RD,   4'd11, 12'h013, 8'h0A},   // R11
        '{T_WR,   4'd10, 12'h555, 8'hAA},   // R10 identifier mode
        '{T_WR,   4'd10, 12'h2AA, 8'h55},
        '{T_WR,   4'd10, 12'h555, 8'h90},
        '{T_RD,   4'd10, 12'h000, 8'h20},
        '{T_RD,   4'd10, 12'h001, 8'hE3},
        '{T_RD,   4'd10, 12'h032, 8'h01},
        '{T_RD,   4'd10, 12'h0A2, 8'h01},
        '{T_RD,   4'd10, 12'h042, 8'h00},
        '{T_RD,   4'd10, 12'h047, 8'h00},
        '{T_WR,   4'd10, 12'h000, 8'hF0},
        '{T_RD,   4'd10, 12'h013, 8'h0A},   // R10 back in read mode
        '{T_ERS,  4'd5,  12'h010, 8'h00},   // R5 erase sector 1
        '{T_IDLE, 4'd5,  12'h000, 8'd70},
        '{T_RD,   4'd5,  12'h013, 8'hFF},
        '{T_RD,   4'd5,  12'h01F, 8'hFF},
        '{T_RD,   4'd5,  12'h092, 8'h3C},   // R5 other sector kept
        '{T_PGM,  4'd6,  12'h035, 8'h00},   // R6 locked sector
        '{T_IDLE, 4'd6,  12'h000, 8'd10},
        '{T_RD,   4'd6,  12'h035, 8'hFF},   // R6
        '{T_PGM,  4'd2,  12'h081, 8'h77},   // R2 first secondary sector
        '{T_IDLE, 4'd2,  12'h000, 8'd10},
        '{T_RD,   4'd2,  12'h081, 8'h77},
        '{T_RD,   4'd2,  12'h071, 8'hFF}    // R2 last primary sector
    };

    logic        clk = 1'b0;
    logic        rst, bus_we, bus_re, ready;
    logic [11:0] bus_addr, lock;
    logic [7:0]  bus_wdata, bus_rdata;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    sector_flash_ctrl #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u0 (
        .clk, .rst, .bus_we, .bus_re, .bus_addr, .bus_wdata,
        .sector_lock(lock), .bus_rdata, .ready
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk_rdy(input string tag, input logic exp);
        chk(tag, {7'b0, ready}, {7'b0, exp});
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [7:0] exp);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pgm(input logic [11:0] a, input logic [7:0] d);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
    endtask

    task automatic ers(input logic [11:0] a);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, 8'h30);
    endtask

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
        lock = 12'h408;                      // sectors 3 and 10 locked
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_rdy("R1 ready after reset", 1'b1);
        chk("R1 rdata after reset", bus_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                T_WR:    wr(VECS[i].addr, VECS[i].data);
                T_RD:    rd($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
                T_IDLE:  idle(int'(VECS[i].data));
                T_PGM:   pgm(VECS[i].addr, VECS[i].data);
                default: ers(VECS[i].addr);
            endcase
        end

        // R7 program busy window
        pgm(12'h020, 8'h40);
        chk_rdy("R7 program busy start", 1'b0);
        for (int c = 1; c < PROG_CYCLES; c++) begin
            @(negedge clk); chk_rdy("R7 program busy", 1'b0);
        end
        @(negedge clk); chk_rdy("R7 program done", 1'b1);
        rd("R4 program result", 12'h020, 8'h40);

        // R8 status polling and ignored writes
        pgm(12'h021, 8'hC0);
        rd("R8 status first", 12'h021, 8'h00);
        rd("R8 status toggled", 12'h500, 8'h40);
        wr(12'h000, 8'hB0);
        chk_rdy("R8 write ignored during program", 1'b0);
        rd("R8 status third", 12'h021, 8'h00);
        idle(10);
        chk_rdy("R8 ready after program", 1'b1);
        rd("R8 data after program", 12'h021, 8'hC0);

        // R7 erase busy window
        ers(12'h040);
        chk_rdy("R7 erase busy start", 1'b0);
        for (int c = 1; c < ERASE_CYCLES; c++) begin
            @(negedge clk); chk_rdy("R7 erase busy", 1'b0);
        end
        @(negedge clk); chk_rdy("R7 erase done", 1'b1);

        // R9 suspend and resume
        pgm(12'h051, 8'h11);
        idle(10);
        rd("R9 setup", 12'h051, 8'h11);
        ers(12'h050);
        idle(10);
        wr(12'h000, 8'hB0);
        chk_rdy("R9 ready while suspended", 1'b1);
        rd("R9 other sector readable", 12'h092, 8'h3C);
        rd("R9 target status", 12'h051, 8'h00);
        rd("R9 target status toggled", 12'h051, 8'h40);
        wr(12'h051, 8'h00);
        idle(100);
        chk_rdy("R9 still suspended", 1'b1);
        rd("R9 not erased while suspended", 12'h051, 8'h00);
        wr(12'h000, 8'h30);
        chk_rdy("R9 resumed busy", 1'b0);
        for (int c = 1; c < ERASE_CYCLES - 10; c++) begin
            @(negedge clk); chk_rdy("R9 remaining busy", 1'b0);
        end
        @(negedge clk); chk_rdy("R9 erase finished", 1'b1);
        rd("R9 erased after resume", 12'h051, 8'hFF);
        rd("R9 neighbour kept", 12'h092, 8'h3C);

        // R6 locked erase and locked program leave ready high
        lock = 12'h008;
        pgm(12'h0A0, 8'h12);
        idle(10);
        lock = 12'h408;
        ers(12'h0A0);
        chk_rdy("R6 locked erase refused", 1'b1);
        idle(70);
        rd("R6 locked sector kept", 12'h0A0, 8'h12);
        pgm(12'h036, 8'h00);
        chk_rdy("R6 locked program refused", 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule